// File: doc/BRIEF.md
# Power-On Startup and Strap Mode Sequencer

This block brings the chip up after its external reset pin is released. The pin is synchronized to the master clock. In the first active cycle after the synchronized release, the block samples the levels on the serial control pins. From those levels it decides whether a host will program the device over the serial port or whether the device runs unattended in standalone mode. In standalone mode the strap on the serial data-out pin also selects whether the ADC serial clocks are driven (master) or received (slave). Register-driven settings are then replaced by fixed defaults. The master clock enable is forced on, and the section power-down bits are treated as clear.

After the straps are captured, an initialization count starts. It advances only while the PLL reports lock. When it has counted a set number of locked master-clock cycles, the block raises a ready flag. A loss of lock during the count clears it back to zero. The per-section power-down bits gate the clock, DAC and ADC section enables. The DAC and ADC enables also wait for ready. The analog output enable is not cleared by reset, so no pop is heard when reset is pulsed.

Top module: `boot_sequencer`

## Requirements
- R1: While the reset pin is low, and for the two master-clock edges after it rises, `ready` is 0, `dac_section_en` and `adc_section_en` are 0, and `clk_section_en` is 1.
- R2: The straps are captured once, at the first clock edge after the synchronized reset release. Later changes on the strap pins have no effect on `standalone` or on the standalone clock-master choice until the next reset.
- R3: `standalone` is 1 only when the captured data-in, clock and latch straps are all 0. A high latch strap, or any other high level on those three pins, selects host mode (`standalone`=0).
- R4: In standalone mode `mclk_enable` is 1 and `adc_clk_master` equals the captured data-out strap (0 = slave, 1 = master). In host mode these outputs follow `cfg_mclk_en` and `cfg_adc_master`.
- R5: `ready` rises after INIT_CYCLES (default 256) consecutive clock edges with `pll_locked` high, counted from the edges after strap capture.
- R6: A clock edge with `pll_locked` low before `ready` clears the count. A full INIT_CYCLES of locked edges is then needed again.
- R7: Once `ready` is 1, it stays 1 until the next reset, whatever `pll_locked` does.
- R8: In host mode, each section enable is registered one cycle after its inputs. `clk_section_en` = not `pd_clk`, `dac_section_en` = `ready` and not `pd_dac`, and `adc_section_en` = `ready` and not `pd_adc`.
- R9: In standalone mode the power-down inputs are ignored and every section is treated as powered up.
- R10: `analog_out_en` is 1 during reset. Outside reset it is registered as not `pd_dac` (host mode) or 1 (standalone mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| strap_din | input | 1 | Serial data-in pin level (strap) |
| strap_dout | input | 1 | Serial data-out pin level (strap, clock master choice) |
| strap_sclk | input | 1 | Serial clock pin level (strap) |
| strap_latch | input | 1 | Serial latch pin level (strap) |
| pll_locked | input | 1 | PLL lock indication |
| cfg_mclk_en | input | 1 | Register value of the internal master clock enable |
| cfg_adc_master | input | 1 | Register value of the ADC clock master select |
| pd_clk | input | 1 | Power-down bit for the PLL and clock section |
| pd_dac | input | 1 | Power-down bit for the DAC section |
| pd_adc | input | 1 | Power-down bit for the ADC section |
| standalone | output | 1 | 1 = standalone mode, 0 = host mode |
| adc_clk_master | output | 1 | ADC serial clock master (1) or slave (0) |
| mclk_enable | output | 1 | Internal master clock enable |
| ready | output | 1 | Initialization complete |
| clk_section_en | output | 1 | Clock section enable |
| dac_section_en | output | 1 | DAC section enable |
| adc_section_en | output | 1 | ADC section enable |
| analog_out_en | output | 1 | Analog output enable |

## Verification
The bench brings the block up under five strap patterns:
- all low with data-out low;
- all low with data-out high;
- latch high;
- data-in high alone;
- clock high alone.

Together these separate the standalone decode from the host decode and the slave choice from the master choice. The lock input is tried three ways:
- held from the start;
- rising late;
- dropped part-way through the count and then dropped again after ready.

The late rise shows that counting waits for lock. The mid-count drop shows that the count restarts. The drop after ready shows that ready is sticky. Power-down bits and strap pins are toggled after capture in both modes. This shows the host-mode gating and registration, the standalone override, and that the captured mode is held.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_INIT  = 2'd1,
        SEQ_READY = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic standalone;
        logic adc_master;
    } strap_t;

    typedef struct packed {
        logic clk_en;
        logic dac_en;
        logic adc_en;
        logic aout_en;
    } sect_en_t;

endpackage

// File: rtl/rst_synchronizer.sv
module rst_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_async,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) chain_q <= '0;
        else              chain_q <= chain_d;
    end

    assign rst_n_sync = chain_q[STAGES-1];

    // R1: the synchronized release never runs ahead of the raw pin
    a_r1_sync_follows_pin: assert property (@(posedge clk) disable iff (!rst_n_async)
        rst_n_sync |-> $past(rst_n_async));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import boot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture,
    input  logic   pin_din,
    input  logic   pin_dout,
    input  logic   pin_sclk,
    input  logic   pin_latch,
    output strap_t strap_o
);
    typedef struct packed {
        strap_t straps;
        logic   taken;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture && !cap_q.taken) begin
            cap_d.straps.standalone = !(pin_din | pin_sclk | pin_latch);
            cap_d.straps.adc_master = pin_dout;
            cap_d.taken             = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign strap_o = cap_q.straps;

    // R2: once taken, the straps do not move until reset
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.taken |=> $stable(cap_q.straps));
endmodule

// File: rtl/init_sequencer.sv
module init_sequencer
    import boot_pkg::*;
#(
    parameter int INIT_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    output logic capture_o,
    output logic ready_o
);
    localparam int CW = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            SEQ_START: seq_d.st = SEQ_INIT;
            SEQ_INIT: begin
                if (!lock) begin
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == LAST) begin
                    seq_d.st  = SEQ_READY;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_READY: seq_d = seq_q;
            default:   seq_d = '{st: SEQ_START, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_START, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign capture_o = (seq_q.st == SEQ_START);
    assign ready_o   = (seq_q.st == SEQ_READY);

    // R5: ready can only appear after a locked edge
    a_r5_ready_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(lock));
    // R6: an unlocked edge while counting restarts the count
    a_r6_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SEQ_INIT && !lock) |=> (seq_q.cnt == '0));
    // R7: ready is sticky
    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);
endmodule

// File: rtl/section_power.sv
module section_power
    import boot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     standalone,
    input  logic     ready,
    input  logic     pd_clk,
    input  logic     pd_dac,
    input  logic     pd_adc,
    output sect_en_t en_o
);
    localparam sect_en_t EN_RESET = '{clk_en: 1'b1, dac_en: 1'b0, adc_en: 1'b0, aout_en: 1'b1};

    sect_en_t en_d, en_q;
    logic eff_pd_clk, eff_pd_dac, eff_pd_adc;

    always_comb begin
        eff_pd_clk = pd_clk & ~standalone;
        eff_pd_dac = pd_dac & ~standalone;
        eff_pd_adc = pd_adc & ~standalone;
        en_d.clk_en  = ~eff_pd_clk;
        en_d.dac_en  = ready & ~eff_pd_dac;
        en_d.adc_en  = ready & ~eff_pd_adc;
        en_d.aout_en = ~eff_pd_dac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= EN_RESET;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R8: converter sections never run before ready
    a_r8_dac_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        en_q.dac_en |-> ready);
    a_r8_adc_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        en_q.adc_en |-> ready);
    // R9: standalone keeps the clock section and analog output up
    a_r9_standalone_up: assert property (@(posedge clk) disable iff (!rst_n)
        standalone |=> (en_q.clk_en && en_q.aout_en));
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int INIT_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic strap_din,
    input  logic strap_dout,
    input  logic strap_sclk,
    input  logic strap_latch,
    input  logic pll_locked,
    input  logic cfg_mclk_en,
    input  logic cfg_adc_master,
    input  logic pd_clk,
    input  logic pd_dac,
    input  logic pd_adc,
    output logic standalone,
    output logic adc_clk_master,
    output logic mclk_enable,
    output logic ready,
    output logic clk_section_en,
    output logic dac_section_en,
    output logic adc_section_en,
    output logic analog_out_en
);
    logic     rst_n_sync;
    logic     capture;
    logic     ready_w;
    strap_t   straps;
    sect_en_t sect_en;

    rst_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n_async (rst_pin_n),
        .rst_n_sync  (rst_n_sync)
    );

    init_sequencer #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n_sync),
        .lock      (pll_locked),
        .capture_o (capture),
        .ready_o   (ready_w)
    );

    strap_capture u_strap (
        .clk       (clk),
        .rst_n     (rst_n_sync),
        .capture   (capture),
        .pin_din   (strap_din),
        .pin_dout  (strap_dout),
        .pin_sclk  (strap_sclk),
        .pin_latch (strap_latch),
        .strap_o   (straps)
    );

    section_power u_pwr (
        .clk        (clk),
        .rst_n      (rst_n_sync),
        .standalone (straps.standalone),
        .ready      (ready_w),
        .pd_clk     (pd_clk),
        .pd_dac     (pd_dac),
        .pd_adc     (pd_adc),
        .en_o       (sect_en)
    );

    always_comb begin
        standalone     = straps.standalone;
        adc_clk_master = straps.standalone ? straps.adc_master : cfg_adc_master;
        mclk_enable    = straps.standalone | cfg_mclk_en;
        ready          = ready_w;
        clk_section_en = sect_en.clk_en;
        dac_section_en = sect_en.dac_en;
        adc_section_en = sect_en.adc_en;
        analog_out_en  = sect_en.aout_en;
    end

    // R1: no readiness in the first synchronized cycle
    a_r1_not_ready_at_release: assert property (@(posedge clk) disable iff (!rst_n_sync)
        $rose(rst_n_sync) |-> !ready);
    // R3: host mode cannot be left without a reset
    a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (!standalone && !capture) |=> !standalone);
endmodule

// File: tb/sim_boot_sequencer.sv
module sim_boot_sequencer;
    localparam int INIT = 256;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0;
    logic strap_din = 1'b0, strap_dout = 1'b0, strap_sclk = 1'b0, strap_latch = 1'b0;
    logic pll_locked = 1'b0, cfg_mclk_en = 1'b0, cfg_adc_master = 1'b0;
    logic pd_clk = 1'b0, pd_dac = 1'b0, pd_adc = 1'b0;
    logic standalone, adc_clk_master, mclk_enable, ready;
    logic clk_section_en, dac_section_en, adc_section_en, analog_out_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    boot_sequencer #(.INIT_CYCLES(INIT)) u0 (.*);

    // behavioural reference model
    int sync_cnt = 0;
    int m_cnt = 0;
    bit m_cap = 0, m_sa = 0, m_am = 0, m_ready = 0;
    bit m_clk = 1, m_dac = 0, m_adc = 0, m_aout = 1;
    bit cmp_on = 0;

    task automatic chk(string tag, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_pin_n || sync_cnt < 2) begin
            if (!rst_pin_n) sync_cnt = 0; else sync_cnt++;
            m_cap = 0; m_sa = 0; m_am = 0; m_ready = 0; m_cnt = 0;
            m_clk = 1; m_dac = 0; m_adc = 0; m_aout = 1;
        end else begin
            m_clk  = m_sa ? 1'b1 : !pd_clk;
            m_aout = m_sa ? 1'b1 : !pd_dac;
            m_dac  = m_ready && (m_sa || !pd_dac);
            m_adc  = m_ready && (m_sa || !pd_adc);
            if (!m_cap) begin
                m_cap = 1;
                m_sa  = !(strap_din || strap_sclk || strap_latch);
                m_am  = strap_dout;
            end else if (!m_ready) begin
                if (!pll_locked)          m_cnt = 0;
                else if (m_cnt == INIT-1) m_ready = 1;
                else                      m_cnt++;
            end
        end
        #5;
        if (cmp_on) begin
            chk("R3", standalone, m_sa, "standalone");
            chk("R4", adc_clk_master, m_sa ? m_am : cfg_adc_master, "adc_clk_master");
            chk("R4", mclk_enable, m_sa ? 1'b1 : cfg_mclk_en, "mclk_enable");
            chk("R5", ready, m_ready, "ready");
            chk("R8", clk_section_en, m_clk, "clk_section_en");
            chk("R8", dac_section_en, m_dac, "dac_section_en");
            chk("R8", adc_section_en, m_adc, "adc_section_en");
            chk("R10", analog_out_en, m_aout, "analog_out_en");
        end
    end

    task automatic sample();
        @(posedge clk); #6;
    endtask

    task automatic do_reset(logic din, logic dout, logic sclk, logic latch, logic lock);
        @(negedge clk);
        rst_pin_n = 0; pll_locked = lock;
        strap_din = din; strap_dout = dout; strap_sclk = sclk; strap_latch = latch;
        repeat (3) sample();
        chk("R1", ready, 1'b0, "ready in reset");
        chk("R1", dac_section_en, 1'b0, "dac_en in reset");
        chk("R1", clk_section_en, 1'b1, "clk_en in reset");
        chk("R10", analog_out_en, 1'b1, "analog_out_en in reset");
        @(negedge clk); rst_pin_n = 1;
        sample(); sample();
        chk("R1", ready, 1'b0, "ready just after release");
        chk("R1", adc_section_en, 1'b0, "adc_en just after release");
    endtask

    task automatic count_to_ready(output int n);
        n = 0;
        while (!ready && n < 2*INIT) begin sample(); n++; end
    endtask

    initial begin
        int n;
        cmp_on = 1;
        // standalone slave, lock present from the start
        do_reset(0, 0, 0, 0, 1);
        sample();
        chk("R3", standalone, 1'b1, "all-low straps");
        chk("R4", adc_clk_master, 1'b0, "standalone slave");
        @(negedge clk); strap_latch = 1; strap_dout = 1; strap_din = 1;
        sample(); sample();
        chk("R2", standalone, 1'b1, "mode after strap change");
        chk("R2", adc_clk_master, 1'b0, "master after strap change");
        @(negedge clk); pd_clk = 1; pd_dac = 1; pd_adc = 1;
        sample(); sample();
        chk("R9", clk_section_en, 1'b1, "pd ignored standalone");
        chk("R9", analog_out_en, 1'b1, "pd ignored standalone aout");
        repeat (INIT) sample();
        chk("R5", ready, 1'b1, "ready after init");
        chk("R9", dac_section_en, 1'b1, "dac up despite pd");
        @(negedge clk); pd_clk = 0; pd_dac = 0; pd_adc = 0;

        // standalone master, late lock
        do_reset(0, 1, 0, 0, 0);
        @(negedge clk); cfg_adc_master = 0; cfg_mclk_en = 0;
        sample();
        chk("R4", adc_clk_master, 1'b1, "standalone master");
        chk("R4", mclk_enable, 1'b1, "mclk forced");
        repeat (20) sample();
        chk("R5", ready, 1'b0, "no ready without lock");
        @(negedge clk); pll_locked = 1;
        count_to_ready(n);
        chk("R5", (n == INIT), 1'b1, "locked cycles to ready");

        // host mode via latch high, lock drop mid count
        do_reset(0, 1, 0, 1, 1);
        sample();
        chk("R3", standalone, 1'b0, "latch high is host");
        @(negedge clk); cfg_adc_master = 1; cfg_mclk_en = 1;
        sample();
        chk("R4", adc_clk_master, 1'b1, "host cfg master");
        @(negedge clk); strap_latch = 0; strap_din = 0; strap_sclk = 0;
        repeat (100) sample();
        chk("R2", standalone, 1'b0, "host held after strap change");
        @(negedge clk); pll_locked = 0;
        repeat (5) sample();
        @(negedge clk); pll_locked = 1;
        count_to_ready(n);
        chk("R6", (n == INIT), 1'b1, "count restarted after unlock");
        @(negedge clk); pll_locked = 0;
        repeat (10) sample();
        chk("R7", ready, 1'b1, "ready sticky on unlock");
        @(negedge clk); pd_dac = 1;
        sample();
        chk("R8", dac_section_en, 1'b0, "pd_dac host");
        chk("R10", analog_out_en, 1'b0, "aout follows pd_dac");
        @(negedge clk); pd_adc = 1; pd_clk = 1; pd_dac = 0;
        sample();
        chk("R8", adc_section_en, 1'b0, "pd_adc host");
        chk("R8", clk_section_en, 1'b0, "pd_clk host");
        chk("R8", dac_section_en, 1'b1, "dac back up");
        @(negedge clk); pd_adc = 0; pd_clk = 0;

        // data-in high alone, clock high alone: host
        do_reset(1, 0, 0, 0, 1);
        sample();
        chk("R3", standalone, 1'b0, "din high is host");
        do_reset(0, 0, 1, 0, 1);
        sample();
        chk("R3", standalone, 1'b0, "sclk high is host");
        repeat (INIT + 4) sample();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule